// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of an 8-bit successive-approximation converter. A trigger source is chosen from five options: a software start of this converter, either of two timer overflow pulses, an external convert-start pin, or a software start aimed at a neighbouring converter. When the chosen trigger fires, the block runs a binary search. It drives a trial code to an external DAC and reads back a single comparator bit. When the search ends it latches the result into a data register.

On completion the block raises a sticky done flag. The interrupt line is that flag gated by an enable. A shutdown input stops any new conversion from starting. The analog parts are outside the block and appear only as ports: the input multiplexer, the gain stage and the comparator. The block presents the channel number and the gain code on outputs for those parts, and holds both steady while a conversion runs.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, busy, done flag and interrupt are 0 and the result register reads 0.
- R2: The trigger-source code picks the start source: 0 = own software start pulse, 1 = timer A overflow, 2 = timer B overflow, 3 = external pin, 4 = neighbour software start. Codes 5 to 7 start nothing. Pulses on sources that are not selected have no effect.
- R3: The external pin passes through a two-flop synchronizer, and only its rising edge starts a conversion. Busy is first seen high after the third clock edge following the pin's rise. A pin that stays high starts only one conversion.
- R4: For a direct source, busy goes high at the clock edge that samples the trigger pulse. Busy then stays high for exactly 9 cycles: 8 trial cycles and 1 latch cycle. The first trial code is 8'h80.
- R5: The search runs from MSB to LSB, one bit per cycle. A trial bit is kept when the comparator input reads 1, meaning the input is at or above the DAC level, and is cleared otherwise. With an ideal comparator the result equals the input code.
- R6: The result register is loaded in the cycle in which busy falls. It holds its value until the next completion.
- R7: The done flag is set in the cycle in which busy falls. It stays set until a clear pulse arrives. If a completion and a clear fall in the same cycle, the completion wins.
- R8: The interrupt output is high exactly when the done flag is set and the interrupt enable is high.
- R9: Triggers that arrive while busy is high are ignored. The running conversion keeps its 9-cycle length and no extra conversion follows.
- R10: While shutdown is high, no conversion starts. A conversion already running finishes normally.
- R11: While idle, the channel and gain outputs follow their select inputs. During a conversion they hold the values captured at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanSel | input | 3 | Requested analog channel |
| gainSel | input | 2 | Gain code (x0.5, x1, x2, x4) |
| trigSel | input | 3 | Start-source select |
| intEn | input | 1 | Interrupt enable |
| shutdown | input | 1 | Blocks new conversions |
| swStart | input | 1 | Own software start pulse |
| tmrAOvf | input | 1 | Timer A overflow pulse |
| tmrBOvf | input | 1 | Timer B overflow pulse |
| extStartPin | input | 1 | Asynchronous convert-start pin |
| peerStart | input | 1 | Neighbour converter software start |
| flagClr | input | 1 | Clears the done flag |
| cmpHigh | input | 1 | Comparator: input >= DAC level |
| dacCode | output | 8 | Trial code to the DAC |
| muxChan | output | 3 | Channel to the multiplexer |
| pgaGain | output | 2 | Gain code to the amplifier |
| busy | output | 1 | Conversion in progress |
| result | output | 8 | Latched conversion result |
| doneFlag | output | 1 | Sticky completion flag |
| irq | output | 1 | Gated completion interrupt |

## Verification
A wrong bit counter or state shows up at once as a busy window that is not 9 cycles long, and the end of that window shows it within the same conversion. A corrupted trial mask or keep/clear rule gives a wrong result code. This appears at the falling edge of busy, because the bench comparator is an ideal threshold, so every result equals the applied input code. A bad synchronizer or edge detector changes the start latency of the pin source, or lets a held pin start again. Either fault is seen within a few cycles of the pin rising.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [2:0] {
    TRIG_SELF  = 3'd0,
    TRIG_TMR_A = 3'd1,
    TRIG_TMR_B = 3'd2,
    TRIG_PIN   = 3'd3,
    TRIG_PEER  = 3'd4
  } trigSrc_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRIAL = 2'd1,
    ST_LATCH = 2'd2
  } sarState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // start search: seed trial with MSB
    logic step;   // resolve current bit, try next
    logic latch;  // copy trial to result, set flag
  } sarStrobe_t;

endpackage

// File: rtl/sar_trig_sel.sv
module sar_trig_sel
  import sar_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] trigSel,
  input  logic       shutdown,
  input  logic       swStart,
  input  logic       tmrAOvf,
  input  logic       tmrBOvf,
  input  logic       extStartPin,
  input  logic       peerStart,
  output logic       fire
);

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] pinChain;
  logic               pinRise;
  logic               picked;

  // synchronizer stages plus one edge-detect stage
  genvar g;
  generate
    for (g = 0; g < CHAIN_W; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) pinChain[g] <= 1'b0;
        else if (g == 0) pinChain[g] <= extStartPin;
        else pinChain[g] <= pinChain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign pinRise = pinChain[SYNC_STAGES-1] & ~pinChain[SYNC_STAGES];

  always_comb begin
    case (trigSel)
      TRIG_SELF:  picked = swStart;
      TRIG_TMR_A: picked = tmrAOvf;
      TRIG_TMR_B: picked = tmrBOvf;
      TRIG_PIN:   picked = pinRise;
      TRIG_PEER:  picked = peerStart;
      default:    picked = 1'b0;
    endcase
  end

  assign fire = picked & ~shutdown;

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fire,
  output sarStrobe_t strb,
  output logic       busy
);

  localparam int CNT_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(RES_W - 1);

  sarState_e        state;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          bitCnt <= '0;
          if (fire) state <= ST_TRIAL;
        end
        ST_TRIAL: begin
          if (bitCnt == LAST_BIT) state <= ST_LATCH;
          else bitCnt <= bitCnt + 1'b1;
        end
        ST_LATCH: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load  = (state == ST_IDLE) && fire;
    strb.step  = (state == ST_TRIAL);
    strb.latch = (state == ST_LATCH);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int RES_W  = 8,
  parameter int CHAN_W = 3,
  parameter int GAIN_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  sarStrobe_t        strb,
  input  logic              busy,
  input  logic              cmpHigh,
  input  logic              flagClr,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic [GAIN_W-1:0] gainSel,
  output logic [RES_W-1:0]  trialCode,
  output logic [RES_W-1:0]  result,
  output logic              doneFlag,
  output logic [CHAN_W-1:0] chanOut,
  output logic [GAIN_W-1:0] gainOut
);

  localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0]  bitMask;
  logic [RES_W-1:0]  resolved;
  logic [CHAN_W-1:0] chanHeld;
  logic [GAIN_W-1:0] gainHeld;

  // keep the bit under trial only when the comparator says input >= DAC
  assign resolved = cmpHigh ? trialCode : (trialCode & ~bitMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trialCode <= '0;
      bitMask   <= '0;
    end else if (strb.load) begin
      trialCode <= MSB_ONE;
      bitMask   <= MSB_ONE;
    end else if (strb.step) begin
      trialCode <= resolved | (bitMask >> 1);
      bitMask   <= bitMask >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      doneFlag <= 1'b0;
    end else begin
      if (strb.latch) result <= trialCode;
      if (strb.latch) doneFlag <= 1'b1;
      else if (flagClr) doneFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanHeld <= '0;
      gainHeld <= '0;
    end else if (strb.load) begin
      chanHeld <= chanSel;
      gainHeld <= gainSel;
    end
  end

  assign chanOut = busy ? chanHeld : chanSel;
  assign gainOut = busy ? gainHeld : gainSel;

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W       = 8,
  parameter int CHAN_W      = 3,
  parameter int GAIN_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic [GAIN_W-1:0] gainSel,
  input  logic [2:0]        trigSel,
  input  logic              intEn,
  input  logic              shutdown,
  input  logic              swStart,
  input  logic              tmrAOvf,
  input  logic              tmrBOvf,
  input  logic              extStartPin,
  input  logic              peerStart,
  input  logic              flagClr,
  input  logic              cmpHigh,
  output logic [RES_W-1:0]  dacCode,
  output logic [CHAN_W-1:0] muxChan,
  output logic [GAIN_W-1:0] pgaGain,
  output logic              busy,
  output logic [RES_W-1:0]  result,
  output logic              doneFlag,
  output logic              irq
);

  logic       fire;
  sarStrobe_t strb;

  sar_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) trig_i (
    .clk(clk), .rstN(rstN), .trigSel(trigSel), .shutdown(shutdown),
    .swStart(swStart), .tmrAOvf(tmrAOvf), .tmrBOvf(tmrBOvf),
    .extStartPin(extStartPin), .peerStart(peerStart), .fire(fire)
  );

  sar_ctrl #(.RES_W(RES_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .fire(fire), .strb(strb), .busy(busy)
  );

  sar_datapath #(.RES_W(RES_W), .CHAN_W(CHAN_W), .GAIN_W(GAIN_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .cmpHigh(cmpHigh),
    .flagClr(flagClr), .chanSel(chanSel), .gainSel(gainSel),
    .trialCode(dacCode), .result(result), .doneFlag(doneFlag),
    .chanOut(muxChan), .gainOut(pgaGain)
  );

  assign irq = doneFlag & intEn;

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int RES_W  = 8,
  parameter int CHAN_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              doneFlag,
  input logic              irq,
  input logic              intEn,
  input logic              shutdown,
  input logic [RES_W-1:0]  dacCode,
  input logic [RES_W-1:0]  result,
  input logic [CHAN_W-1:0] muxChan
);

  localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

  int unsigned busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= 0;
    else if (busy) busyCnt <= busyCnt + 1;
    else busyCnt <= 0;
  end

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyCnt == RES_W + 1);

  p_first_trial_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> dacCode == MSB_ONE);

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(busy) |-> $stable(result));

  p_flag_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $fell(busy));

  p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    (intEn && $rose(doneFlag)) |-> irq);

  p_no_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    (shutdown && !busy) |=> !busy);

  p_chan_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(muxChan));

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.RES_W(RES_W), .CHAN_W(CHAN_W)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .doneFlag(doneFlag), .irq(irq),
  .intEn(intEn), .shutdown(shutdown), .dacCode(dacCode), .result(result),
  .muxChan(muxChan)
);

// File: tb/sar_conv_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] chanSel;
  logic [1:0] gainSel;
  logic [2:0] trigSel;
  logic       intEn, shutdown, swStart, tmrAOvf, tmrBOvf, extStartPin, peerStart, flagClr;
  logic       cmpHigh;
  logic [7:0] dacCode, result;
  logic [2:0] muxChan;
  logic [1:0] pgaGain;
  logic       busy, doneFlag, irq;
  logic [7:0] vin;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // ideal comparator: input at or above DAC level
  assign cmpHigh = (vin >= dacCode);

  sar_conv_ctrl dut_i (
    .clk(clk), .rstN(rstN), .chanSel(chanSel), .gainSel(gainSel), .trigSel(trigSel),
    .intEn(intEn), .shutdown(shutdown), .swStart(swStart), .tmrAOvf(tmrAOvf),
    .tmrBOvf(tmrBOvf), .extStartPin(extStartPin), .peerStart(peerStart),
    .flagClr(flagClr), .cmpHigh(cmpHigh), .dacCode(dacCode), .muxChan(muxChan),
    .pgaGain(pgaGain), .busy(busy), .result(result), .doneFlag(doneFlag), .irq(irq)
  );

  function automatic logic [7:0] sarModel(input logic [7:0] v);
    logic [7:0] c = 8'h00;
    for (int b = 7; b >= 0; b--) begin
      logic [7:0] t = c | (8'h01 << b);
      if (v >= t) c = t;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int src, input logic val);
    case (src)
      0: swStart = val;
      1: tmrAOvf = val;
      2: tmrBOvf = val;
      3: extStartPin = val;
      4: peerStart = val;
      default: ;
    endcase
  endtask

  // pulse the selected source for one cycle, return cycles until busy seen
  task automatic startConv(input int src, input logic [7:0] v, output int lat);
    trigSel = 3'(src);
    vin = v;
    drive(src, 1'b1);
    @(negedge clk);
    drive(src, 1'b0);
    lat = 1;
    while (!busy && lat < 10) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic finishConv(input int already, output int len);
    len = already;
    while (busy && len < 20) begin
      @(negedge clk);
      len++;
    end
  endtask

  task automatic pulseClr();
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic fullConv(input int src, input logic [7:0] v, input string tag);
    int lat, len;
    int expLat = (src == 3) ? 3 : 1;
    startConv(src, v, lat);
    check(lat == expLat, tag, lat, expLat);
    finishConv(0, len);
    check(len == 9, "R4 busy length", len, 9);
    check(result == sarModel(v), "R5 result", result, sarModel(v));
    check(doneFlag == 1'b1, "R7 flag set", doneFlag, 1);
  endtask

  task automatic watchIdle(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nBad++;
      nChk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int lat, len;
    logic [7:0] keep;
    void'($urandom(32'h1234_abcd));
    rstN = 1'b0; chanSel = 3'd0; gainSel = 2'd0; trigSel = 3'd0; intEn = 1'b0;
    shutdown = 1'b0; swStart = 1'b0; tmrAOvf = 1'b0; tmrBOvf = 1'b0;
    extStartPin = 1'b0; peerStart = 1'b0; flagClr = 1'b0; vin = 8'h00;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(doneFlag == 1'b0, "R1 flag", doneFlag, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(result == 8'h00, "R1 result", result, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: each source with directed corner values
    fullConv(0, 8'h00, "R2 self start latency");
    pulseClr();
    fullConv(1, 8'hFF, "R2 timer A latency");
    pulseClr();
    fullConv(2, 8'h80, "R2 timer B latency");
    pulseClr();
    fullConv(3, 8'h7F, "R3 pin latency");
    pulseClr();
    fullConv(4, 8'h55, "R2 peer latency");

    // R7 flag sticky, then cleared
    repeat (5) @(negedge clk);
    check(doneFlag == 1'b1, "R7 flag sticky", doneFlag, 1);
    pulseClr();
    check(doneFlag == 1'b0, "R7 flag cleared", doneFlag, 0);

    // R7 completion beats clear in same cycle
    startConv(0, 8'hA5, lat);
    repeat (8) @(negedge clk);
    flagClr = 1'b1;
    finishConv(8, len);
    check(doneFlag == 1'b1, "R7 set wins over clear", doneFlag, 1);
    @(negedge clk);
    flagClr = 1'b0;
    check(doneFlag == 1'b0, "R7 clear next cycle", doneFlag, 0);

    // R8 interrupt gating
    intEn = 1'b0;
    fullConv(1, 8'h3C, "R2 timer A latency");
    check(irq == 1'b0, "R8 irq masked", irq, 0);
    intEn = 1'b1;
    #1;
    check(irq == 1'b1, "R8 irq enabled", irq, 1);
    @(negedge clk);
    pulseClr();
    check(irq == 1'b0, "R8 irq after clear", irq, 0);

    // R2 unselected sources ignored
    trigSel = 3'd1;
    swStart = 1'b1; tmrBOvf = 1'b1; peerStart = 1'b1; extStartPin = 1'b1;
    @(negedge clk);
    swStart = 1'b0; tmrBOvf = 1'b0; peerStart = 1'b0; extStartPin = 1'b0;
    watchIdle(6, "R2 unselected ignored");
    for (int code = 5; code < 8; code++) begin
      trigSel = 3'(code);
      swStart = 1'b1; tmrAOvf = 1'b1; tmrBOvf = 1'b1; peerStart = 1'b1; extStartPin = 1'b1;
      @(negedge clk);
      swStart = 1'b0; tmrAOvf = 1'b0; tmrBOvf = 1'b0; peerStart = 1'b0; extStartPin = 1'b0;
      watchIdle(6, "R2 reserved code idle");
    end

    // R9 retrigger while busy ignored
    startConv(0, 8'h96, lat);
    repeat (3) @(negedge clk);
    swStart = 1'b1;
    @(negedge clk);
    swStart = 1'b0;
    finishConv(4, len);
    check(len == 9, "R9 length unchanged", len, 9);
    check(result == 8'h96, "R9 first result kept", result, 8'h96);
    watchIdle(4, "R9 no extra conversion");
    pulseClr();

    // R3 pin held high: one conversion only
    trigSel = 3'd3;
    vin = 8'h21;
    extStartPin = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R3 pin start", busy, 1);
    finishConv(0, len);
    watchIdle(15, "R3 held pin no retrigger");
    extStartPin = 1'b0;
    check(result == 8'h21, "R3 pin result", result, 8'h21);
    pulseClr();

    // R10 shutdown blocks start, running conversion completes
    shutdown = 1'b1;
    trigSel = 3'd0;
    swStart = 1'b1;
    @(negedge clk);
    swStart = 1'b0;
    watchIdle(4, "R10 shutdown blocks");
    shutdown = 1'b0;
    startConv(0, 8'hC3, lat);
    repeat (2) @(negedge clk);
    shutdown = 1'b1;
    finishConv(2, len);
    check(len == 9, "R10 runs to end", len, 9);
    check(result == 8'hC3, "R10 result", result, 8'hC3);
    shutdown = 1'b0;
    pulseClr();

    // R11 channel and gain capture
    chanSel = 3'd3; gainSel = 2'd2;
    #1;
    check(muxChan == 3'd3, "R11 idle chan follows", muxChan, 3);
    check(pgaGain == 2'd2, "R11 idle gain follows", pgaGain, 2);
    startConv(0, 8'h10, lat);
    chanSel = 3'd6; gainSel = 2'd1;
    repeat (2) @(negedge clk);
    check(muxChan == 3'd3, "R11 chan held", muxChan, 3);
    check(pgaGain == 2'd2, "R11 gain held", pgaGain, 2);
    finishConv(2, len);
    check(muxChan == 3'd6, "R11 chan after", muxChan, 6);

    // R6 result holds while idle and input changes
    keep = result;
    vin = 8'hEE;
    repeat (6) @(negedge clk);
    check(result == keep, "R6 result held", result, keep);
    pulseClr();

    // random conversions
    for (int n = 0; n < 60; n++) begin
      int src = int'($urandom_range(4, 0));
      logic [7:0] v = 8'($urandom);
      intEn = 1'($urandom);
      chanSel = 3'($urandom);
      fullConv(src, v, (src == 3) ? "R3 pin latency" : "R2 start latency");
      check(irq == intEn, "R8 random irq", irq, intEn);
      pulseClr();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule